// File: doc/BRIEF.md
# Parallel Binary Matched Filter with Boundary Peak Search

This block locates the start of an OFDM symbol window in a stream of complex samples. Each cycle it can receive one window of 32 stored 4-bit I/Q samples and correlates that window against four separate sets of 32 one-bit taps. Each set is one of four sub-filters working in parallel, so each cycle covers four sample positions. Every tap is +1 or -1, so each sub-filter needs only a signed add or subtract per sample, with no multipliers. Each sub-filter adds its 32 terms and squares the I and Q totals to form a correlation power.

A peak search keeps the five strongest (power, index) candidates seen since the last start. At the end of a search of programmable length, the block reports a boundary. The reported boundary is the earliest candidate among those five whose power reaches half of the maximum. Reporting this early peak rather than the largest one avoids locking onto a delayed multipath echo. The caller pulses `start`, supplies windows with `win_valid`, and reads the result when `done` pulses.

Top module: `parallel_mf_boundary`

## Requirements
- R1: Tap bit `taps[s*32+k]` applies to window word k (`win_i`/`win_q` bits `k*4 +: 4`, two's complement) in sub-filter s. A tap bit of 1 adds the sample and a tap bit of 0 subtracts it, independently for I and Q.
- R2: A candidate's power is sum_I squared plus sum_Q squared, at full precision. A sum can reach ±256, so a power can reach 131072.
- R3: The four sub-filters read the same window in the same cycle. The candidate from sub-filter s in the w-th accepted window after start (w counted from 0) has index w*4+s.
- R4: The search retains the five strongest candidates since start. Between equal powers, the lower index ranks higher.
- R5: At completion, the reported boundary is the lowest index among the retained candidates whose doubled power is at least the retained maximum. `boundary_pwr` reports that candidate's power.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the clock edge that accepts the window bringing the accepted count to `search_len`. No window is accepted after that until the next start.
- R7: `start` empties the candidate list and restarts the window count, including in the middle of a search.
- R8: A window offered while no search is running, or in the same cycle as `start`, is ignored.
- R9: After reset, `done`, `boundary_idx` and `boundary_pwr` are 0 and no search is running.
- R10: A `search_len` of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search, clearing candidates |
| search_len | input | 16 | Number of windows in the search, sampled at start |
| win_valid | input | 1 | Window present this cycle |
| win_i | input | 128 | 32 in-phase samples, 4 bits each |
| win_q | input | 128 | 32 quadrature samples, 4 bits each |
| taps | input | 128 | 32 sign bits for each of 4 sub-filters |
| boundary_idx | output | 18 | Selected boundary index |
| boundary_pwr | output | 19 | Power of the selected candidate |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports involve the five-entry list itself. One is an early candidate being pushed out by later, stronger ones. Another is a candidate sitting at exactly half of the maximum. Constant windows cannot produce these power ratios, so the bench uses windows with only one or two non-zero words. These make chosen powers such as 25, 50, 72, 98 and 100 appear at chosen indices over multi-window searches. A table of single-window searches with uniform samples and tap sets of chosen weight then exercises the sign convention and the per-sub-filter powers.

// File: rtl/parallel_mf_boundary.sv
module parallel_mf_boundary #(
  parameter int NSUB  = 4,
  parameter int NTAP  = 32,
  parameter int DW    = 4,
  parameter int CW    = 16,
  parameter int DEPTH = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [CW-1:0]                      search_len,
  input  logic                               win_valid,
  input  logic [NTAP*DW-1:0]                 win_i,
  input  logic [NTAP*DW-1:0]                 win_q,
  input  logic [NSUB*NTAP-1:0]               taps,
  output logic [CW+$clog2(NSUB)-1:0]         boundary_idx,
  output logic [2*(DW+$clog2(NTAP)+1)-2:0]   boundary_pwr,
  output logic                               done
);
  localparam int SW = DW + $clog2(NTAP) + 1;
  localparam int PW = 2 * SW - 1;
  localparam int IW = CW + $clog2(NSUB);
  localparam int NC = DEPTH + NSUB;

  logic          active;
  logic [CW-1:0] cnt, len;
  logic [PW-1:0] lp [DEPTH];
  logic [IW-1:0] li [DEPTH];
  logic [DEPTH-1:0] lv;

  wire accept = active && win_valid && !start;
  wire last   = accept && (({1'b0, cnt} + 1'b1) >= {1'b0, len});

  logic [PW-1:0] pw [NSUB];

  always_comb begin
    for (int s = 0; s < NSUB; s++) begin
      logic signed [SW-1:0]   ai, aq;
      logic signed [DW-1:0]   xi, xq;
      logic signed [2*SW-1:0] sq;
      ai = '0;
      aq = '0;
      for (int k = 0; k < NTAP; k++) begin
        xi = win_i[k*DW +: DW];
        xq = win_q[k*DW +: DW];
        if (taps[s*NTAP + k]) begin
          ai = ai + SW'(xi);
          aq = aq + SW'(xq);
        end else begin
          ai = ai - SW'(xi);
          aq = aq - SW'(xq);
        end
      end
      sq = ai * ai + aq * aq;
      pw[s] = PW'(sq);
    end
  end

  logic [PW-1:0] cp [NC];
  logic [IW-1:0] ci [NC];
  logic [NC-1:0] cv;
  logic [PW-1:0] np [DEPTH];
  logic [IW-1:0] ni [DEPTH];
  logic [DEPTH-1:0] nv;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      cp[j] = lp[j];
      ci[j] = li[j];
      cv[j] = lv[j];
    end
    for (int s = 0; s < NSUB; s++) begin
      cp[DEPTH+s] = pw[s];
      ci[DEPTH+s] = IW'(cnt) * IW'(NSUB) + IW'(s);
      cv[DEPTH+s] = accept;
    end
  end

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      np[j] = '0;
      ni[j] = '0;
    end
    nv = '0;
    for (int k = 0; k < NC; k++) begin
      int rk;
      rk = 0;
      for (int j = 0; j < NC; j++)
        if (j != k && cv[j] &&
            (cp[j] > cp[k] || (cp[j] == cp[k] && ci[j] < ci[k])))
          rk = rk + 1;
      if (cv[k] && rk < DEPTH) begin
        np[rk] = cp[k];
        ni[rk] = ci[k];
        nv[rk] = 1'b1;
      end
    end
  end

  logic [PW-1:0] sel_p;
  logic [IW-1:0] sel_i;

  always_comb begin
    logic found;
    found = 1'b0;
    sel_p = '0;
    sel_i = '0;
    for (int j = 0; j < DEPTH; j++)
      if (nv[j] && {np[j], 1'b0} >= {1'b0, np[0]} && (!found || ni[j] < sel_i)) begin
        found = 1'b1;
        sel_p = np[j];
        sel_i = ni[j];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      cnt          <= '0;
      len          <= '0;
      lv           <= '0;
      done         <= 1'b0;
      boundary_idx <= '0;
      boundary_pwr <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        lp[j] <= '0;
        li[j] <= '0;
      end
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      len    <= search_len;
      lv     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cnt <= cnt + 1'b1;
        lv  <= nv;
        for (int j = 0; j < DEPTH; j++) begin
          lp[j] <= np[j];
          li[j] <= ni[j];
        end
      end
      if (last) begin
        active       <= 1'b0;
        done         <= 1'b1;
        boundary_idx <= sel_i;
        boundary_pwr <= sel_p;
      end
    end
  end

  for (genvar j = 0; j < DEPTH - 1; j++) begin : g_order
    assert_list_sorted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lv[j+1] |-> (lv[j] && lp[j] >= lp[j+1]));
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_precursor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({boundary_pwr, 1'b0} >= {1'b0, lp[0]} && boundary_idx <= li[0]));

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (lv == '0));

  assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> ($stable(lv) && !done));

endmodule

// File: tb/parallel_mf_boundary_test.sv
module parallel_mf_boundary_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  search_len = '0;
  logic         win_valid = 1'b0;
  logic [127:0] win_i = '0, win_q = '0, taps = '0;
  logic [17:0]  boundary_idx;
  logic [18:0]  boundary_pwr;
  logic         done;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  parallel_mf_boundary uut (
    .clk(clk), .rst_n(rst_n), .start(start), .search_len(search_len),
    .win_valid(win_valid), .win_i(win_i), .win_q(win_q), .taps(taps),
    .boundary_idx(boundary_idx), .boundary_pwr(boundary_pwr), .done(done));

  // a, b, ones in sub0..sub3 taps, expected index, expected power
  localparam int NV = 5;
  localparam int TV [NV][8] = '{
    '{ 1,  0, 32, 16, 16, 16, 0,   1024},
    '{ 2, -1, 16,  0, 20, 16, 1,   5120},
    '{-8, -8,  0, 32,  0, 32, 0, 131072},
    '{ 7,  7, 16, 17, 24, 31, 3,  88200},
    '{ 3,  4, 24, 16, 31, 32, 2,  22500}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] fill(input int v);
    logic [127:0] r;
    for (int k = 0; k < 32; k++) r[k*4 +: 4] = 4'(v);
    return r;
  endfunction

  function automatic logic [127:0] word0(input int v);
    return {124'b0, 4'(v)};
  endfunction

  function automatic logic [31:0] ones(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic begin_search(input int n);
    @(negedge clk);
    start = 1'b1;
    search_len = 16'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input logic [127:0] wi, input logic [127:0] wq);
    win_i = wi;
    win_q = wq;
    win_valid = 1'b1;
    @(negedge clk);
    win_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #35;
    check("R9 done", 32'(done), 0);
    check("R9 idx", 32'(boundary_idx), 0);
    check("R9 pwr", 32'(boundary_pwr), 0);
    rst_n = 1'b1;

    // R1 R2 R3 single-window table
    for (int v = 0; v < NV; v++) begin
      taps = {ones(TV[v][5]), ones(TV[v][4]), ones(TV[v][3]), ones(TV[v][2])};
      begin_search(1);
      feed(fill(TV[v][0]), fill(TV[v][1]));
      check("R6 done after window", 32'(done), 1);
      check("R1 R3 boundary index", 32'(boundary_idx), 32'(TV[v][6]));
      check("R2 boundary power", 32'(boundary_pwr), 32'(TV[v][7]));
    end

    // R4 eviction, R6 pulse timing
    taps = '1;
    begin_search(3);
    feed(word0(5), word0(5));
    check("R6 no early done", 32'(done), 0);
    feed(word0(7), word0(7));
    check("R6 no early done", 32'(done), 0);
    feed(word0(6), word0(6));
    check("R6 done on last", 32'(done), 1);
    check("R4 eviction idx", 32'(boundary_idx), 4);
    check("R4 eviction pwr", 32'(boundary_pwr), 98);
    @(negedge clk);
    check("R6 single pulse", 32'(done), 0);

    // R5 exact half qualifies
    begin_search(2);
    feed(word0(3), word0(4));
    feed(word0(5), word0(5));
    check("R5 half idx", 32'(boundary_idx), 0);
    check("R5 half pwr", 32'(boundary_pwr), 25);

    // R4 tie keeps earlier index
    begin_search(2);
    feed(word0(5), word0(5));
    feed(word0(5), word0(5));
    check("R4 tie idx", 32'(boundary_idx), 0);

    // R3 later window, nonzero sub-filter; R1 per-word sign
    taps = {32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE};
    begin_search(2);
    feed(word0(1), word0(0));
    feed({120'b0, 4'd3, 4'd3}, {120'b0, 4'd4, 4'd4});
    check("R3 sub3 idx", 32'(boundary_idx), 7);
    check("R1 two-word pwr", 32'(boundary_pwr), 100);

    // R8 idle window ignored
    taps = '1;
    feed(word0(7), word0(7));
    check("R8 idle no done", 32'(done), 0);
    check("R8 idle pwr held", 32'(boundary_pwr), 100);

    // R8 window during start ignored
    @(negedge clk);
    start = 1'b1;
    search_len = 16'd1;
    win_i = word0(7);
    win_q = word0(7);
    win_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    win_valid = 1'b0;
    check("R8 start window no done", 32'(done), 0);
    feed(word0(1), word0(0));
    check("R8 done after real window", 32'(done), 1);
    check("R8 start window ignored", 32'(boundary_pwr), 1);

    // R7 restart mid-search
    begin_search(2);
    feed(word0(7), word0(7));
    begin_search(1);
    feed(word0(1), word0(0));
    check("R7 restart done", 32'(done), 1);
    check("R7 restart pwr", 32'(boundary_pwr), 1);
    check("R7 restart idx", 32'(boundary_idx), 0);

    // R10 zero length
    begin_search(0);
    feed(word0(2), word0(0));
    check("R10 zero len done", 32'(done), 1);
    check("R10 zero len pwr", 32'(boundary_pwr), 4);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule